// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a 32-bit processor core in which every instruction completes within one clock period. It executes register-to-register arithmetic and logic operations, word loads and stores, branch-on-equal and an absolute jump. It contains its own program counter, a 32-entry register file, an instruction store and a data store. The two stores are separate word arrays, so a data access never competes with instruction fetch.

The program and the initial data are written through a load port. The port only takes effect while reset is held. When reset is released, execution starts at address 0. Two observation outputs are provided for checking. One shows the current program counter. The other shows the register-file write that the current instruction performs at the next clock edge.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and `rf_we_o` is 0. The load port writes word `ld_addr` of the instruction store (`ld_imem_we`) or of the data store (`ld_dmem_we`) at each clock edge. After release, the first instruction fetched is the one at byte address 0.
- R2: An instruction word is split into fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0]. Opcode 0x00 is a register operation that writes rd. The function code selects the operation: 0x20 add, 0x22 subtract (rs−rt), 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0).
- R3: Opcode 0x23 (load) writes register rt with the data word at byte address rs + sign-extended immediate. The word index is taken from address bits above bit 1.
- R4: Opcode 0x2B (store) writes rt into the data word at byte address rs + sign-extended immediate. It performs no register write, and a later load from that address returns the stored value.
- R5: Opcode 0x04 (branch-on-equal) performs no register write. When rs equals rt, the next PC is PC+4 plus the sign-extended immediate shifted left by 2; negative offsets branch backward. When rs differs from rt, the next PC is PC+4. Every other instruction that is not a jump advances the PC by 4.
- R6: Opcode 0x02 (jump) loads the PC with bits [31:28] of PC+4, followed by instruction bits [25:0], followed by two zero bits. It performs no register write.
- R7: Register 0 always reads as zero. A write that targets register 0 is discarded and is not shown on `rf_we_o`.
- R8: An unsupported opcode, or a register operation with an unsupported function code, writes neither a register nor the data store, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; enables the load port while low |
| ld_imem_we | input | 1 | Load port write strobe for the instruction store |
| ld_dmem_we | input | 1 | Load port write strobe for the data store |
| ld_addr | input | LD_AW | Word index written by the load port |
| ld_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Byte address of the instruction now executing |
| rf_we_o | output | 1 | The current instruction writes a register at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |

## Verification
Any fault in the PC state or in the next-PC selection shows on `pc_o` in the very next cycle. Every later write then appears at a shifted cycle or is missing altogether. A corrupted register, or a lost store, stays hidden until an instruction reads it. Because of this, the test program follows each producing instruction closely with a consumer whose result appears on the write observation port. A wrong value therefore surfaces within a few cycles. Branch direction depends on whether the two operands are equal, so both branch outcomes are exercised in every run by sweeping operand pairs that include equal values.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_JMP   = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // class-level ALU request from the main decoder
    localparam logic [1:0] AQ_ADD  = 2'b00;
    localparam logic [1:0] AQ_SUB  = 2'b01;
    localparam logic [1:0] AQ_FUNC = 2'b10;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT,
        ALU_NONE
    } alu_fn_e;

    typedef struct packed {
        logic       dst_is_rd;
        logic [1:0] alu_req;
        logic       use_imm;
        logic       is_branch;
        logic       rd_mem;
        logic       wr_mem;
        logic       wr_reg;
        logic       wb_from_mem;
        logic       is_jump;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/sc_ctrl.sv
`timescale 1ns/1ps
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_fn_e    alu_fn
);

    // first level: instruction class
    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_req   = AQ_FUNC;
                ctrl.wr_reg    = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.alu_req     = AQ_ADD;
                ctrl.use_imm     = 1'b1;
                ctrl.rd_mem      = 1'b1;
                ctrl.wr_reg      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.alu_req = AQ_ADD;
                ctrl.use_imm = 1'b1;
                ctrl.wr_mem  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.alu_req   = AQ_SUB;
                ctrl.is_branch = 1'b1;
            end
            OPC_JMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

    // second level: operation from class request and function field
    always_comb begin
        alu_fn = ALU_NONE;
        case (ctrl.alu_req)
            AQ_ADD:  alu_fn = ALU_ADD;
            AQ_SUB:  alu_fn = ALU_SUB;
            AQ_FUNC: begin
                case (funct)
                    FN_ADD:  alu_fn = ALU_ADD;
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: alu_fn = ALU_NONE;
                endcase
            end
            default: alu_fn = ALU_NONE;
        endcase
    end

    // R4: a store never also requests a register write
    always_comb begin
        p_store_no_wb_r4: assert (!(ctrl.wr_mem && ctrl.wr_reg));
    end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);

    logic [W-1:0] regs_d [NREG];
    logic [W-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && (waddr != '0)) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    parameter int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_imem_we,
    input  logic             ld_dmem_we,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [31:0]      ld_data,
    output logic [31:0]      pc_o,
    output logic             rf_we_o,
    output logic [4:0]       rf_waddr_o,
    output logic [31:0]      rf_wdata_o
);

    localparam int IMEM_WORDS = 1 << IMEM_AW;
    localparam int DMEM_WORDS = 1 << DMEM_AW;

    core_state_t state_d, state_q;

    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];

    logic [XLEN-1:0] instr;
    ctrl_t           ctrl;
    alu_fn_e         alu_fn;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, mem_rdata;
    logic            alu_zero, branch_taken, dmem_we_core;
    logic [XLEN-1:0] pc_plus4, br_target, jmp_target;
    logic [RIDX-1:0] rf_waddr;
    logic [XLEN-1:0] rf_wdata;
    logic            rf_we;

    // fetch
    assign instr = imem_q[state_q.pc[IMEM_AW+1:2]];

    sc_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl),
        .alu_fn (alu_fn)
    );

    sc_regfile #(.W(XLEN), .NREG(32)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .ra1   (instr[25:21]),
        .ra2   (instr[20:16]),
        .rd1   (rs_val),
        .rd2   (rt_val)
    );

    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data access
    assign mem_rdata    = ctrl.rd_mem ? dmem_q[alu_y[DMEM_AW+1:2]] : '0;
    assign dmem_we_core = rst_n && ctrl.wr_mem;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (ld_dmem_we) dmem_q[ld_addr[DMEM_AW-1:0]] <= ld_data;
            if (ld_imem_we) imem_q[ld_addr[IMEM_AW-1:0]] <= ld_data;
        end else if (dmem_we_core) begin
            dmem_q[alu_y[DMEM_AW+1:2]] <= rt_val;
        end
    end

    // write back
    assign rf_waddr = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
    assign rf_wdata = ctrl.wb_from_mem ? mem_rdata : alu_y;
    assign rf_we    = rst_n && ctrl.wr_reg && (alu_fn != ALU_NONE)
                      && (rf_waddr != '0);

    // next PC
    assign pc_plus4     = state_q.pc + 32'd4;
    assign br_target    = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target   = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign branch_taken = ctrl.is_branch && alu_zero;

    always_comb begin
        state_d = state_q;
        if (ctrl.is_jump) begin
            state_d.pc = jmp_target;
        end else if (branch_taken) begin
            state_d.pc = br_target;
        end else begin
            state_d.pc = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o       = state_q.pc;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = rf_waddr;
    assign rf_wdata_o = rf_wdata;

    // R1: nothing is written by the core while reset is held
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!rf_we_o && !dmem_we_core);
        end
    end

    // R5: sequential flow advances by one word
    p_pc_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!branch_taken && !ctrl.is_jump) |=> (state_q.pc == $past(state_q.pc) + 32'd4));

    // R6: jump places the 26-bit field into the word-address bits
    p_jump_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.is_jump |=> (state_q.pc[27:2] == $past(instr[25:0])));

    // R7: a reported write never targets register 0
    p_r0_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (rf_waddr_o != 5'd0));

endmodule

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_imem_we, ld_dmem_we;
    logic [5:0]  ld_addr;
    logic [31:0] ld_data;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sc_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_imem_we (ld_imem_we),
        .ld_dmem_we (ld_dmem_we),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    localparam int PROG_LEN = 22;

    function automatic logic [31:0] prog(int k);
        case (k)
            0:  return enc_i(6'h23, 0, 1, 16'd0);      // load r1 <- word 0
            1:  return enc_i(6'h23, 0, 2, 16'd4);      // load r2 <- word 1
            2:  return enc_r(1, 2, 3, 6'h20);
            3:  return enc_r(1, 2, 4, 6'h22);
            4:  return enc_r(1, 2, 5, 6'h24);
            5:  return enc_r(1, 2, 6, 6'h25);
            6:  return enc_r(1, 2, 7, 6'h2A);
            7:  return enc_r(2, 1, 8, 6'h2A);
            8:  return enc_i(6'h2B, 0, 4, 16'd12);     // store r4 -> word 3
            9:  return enc_i(6'h23, 0, 9, 16'd12);     // load r9 <- word 3
            10: return enc_r(1, 2, 0, 6'h20);          // write to r0
            11: return enc_r(0, 1, 10, 6'h20);         // r10 = r0 + r1
            12: return enc_i(6'h04, 1, 2, 16'd2);      // beq -> 60
            13: return enc_r(1, 1, 11, 6'h20);
            14: return {6'h02, 26'd16};                // jump -> 64
            15: return enc_r(2, 0, 12, 6'h20);
            16: return enc_r(2, 1, 13, 6'h22);
            17: return enc_i(6'h04, 0, 0, 16'd1);      // always taken -> 76
            18: return enc_r(1, 2, 16, 6'h20);         // skipped
            19: return enc_r(1, 2, 17, 6'h3F);         // bad function
            20: return enc_i(6'h08, 1, 18, 16'd5);     // bad opcode
            21: return enc_i(6'h04, 0, 0, 16'hFFFF);   // branch to self
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] val(int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [31:0] slt(logic [31:0] a, logic [31:0] b);
        return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic step(string tag, logic [31:0] e_pc, logic e_we,
                        logic [4:0] e_wa, logic [31:0] e_wd);
        chk({tag, " pc"}, pc_o, e_pc);
        chk({tag, " we"}, {31'd0, rf_we_o}, {31'd0, e_we});
        if (e_we) begin
            chk({tag, " waddr"}, {27'd0, rf_waddr_o}, {27'd0, e_wa});
            chk({tag, " wdata"}, rf_wdata_o, e_wd);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(logic [31:0] a, logic [31:0] b);
        rst_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < PROG_LEN; k++) begin
            ld_imem_we = 1'b1; ld_addr = 6'(k); ld_data = prog(k);
            @(negedge clk);
        end
        ld_imem_we = 1'b0;
        for (int k = 0; k < 4; k++) begin
            ld_dmem_we = 1'b1; ld_addr = 6'(k);
            ld_data = (k == 0) ? a : (k == 1) ? b : 32'hDEAD_0000;
            @(negedge clk);
        end
        ld_dmem_we = 1'b0;
        // R1: reset state
        chk("R1 reset pc", pc_o, 32'd0);
        chk("R1 reset we", {31'd0, rf_we_o}, 32'd0);
        rst_n = 1'b1;
        #1;
        step("R3 load r1",  32'd0,  1'b1, 5'd1, a);
        step("R3 load r2",  32'd4,  1'b1, 5'd2, b);
        step("R2 add",      32'd8,  1'b1, 5'd3, a + b);
        step("R2 sub",      32'd12, 1'b1, 5'd4, a - b);
        step("R2 and",      32'd16, 1'b1, 5'd5, a & b);
        step("R2 or",       32'd20, 1'b1, 5'd6, a | b);
        step("R2 slt",      32'd24, 1'b1, 5'd7, slt(a, b));
        step("R2 slt swap", 32'd28, 1'b1, 5'd8, slt(b, a));
        step("R4 store",    32'd32, 1'b0, 5'd0, 32'd0);
        step("R4 reload",   32'd36, 1'b1, 5'd9, a - b);
        step("R7 r0 write", 32'd40, 1'b0, 5'd0, 32'd0);
        step("R7 r0 read",  32'd44, 1'b1, 5'd10, a);
        step("R5 beq",      32'd48, 1'b0, 5'd0, 32'd0);
        if (a != b) begin
            step("R5 not taken", 32'd52, 1'b1, 5'd11, a + a);
            step("R6 jump",      32'd56, 1'b0, 5'd0, 32'd0);
        end else begin
            step("R5 taken",     32'd60, 1'b1, 5'd12, b);
        end
        step("R6 target",   32'd64, 1'b1, 5'd13, b - a);
        step("R5 fwd beq",  32'd68, 1'b0, 5'd0, 32'd0);
        step("R8 bad func", 32'd76, 1'b0, 5'd0, 32'd0);
        step("R8 bad opc",  32'd80, 1'b0, 5'd0, 32'd0);
        for (int k = 0; k < 3; k++) begin
            step("R5 back beq", 32'd84, 1'b0, 5'd0, 32'd0);
        end
    endtask

    initial begin
        rst_n      = 1'b0;
        ld_imem_we = 1'b0;
        ld_dmem_we = 1'b0;
        ld_addr    = '0;
        ld_data    = '0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                run(val(i), val(j));
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule